// File: doc/BRIEF.md
# UART Receive Idle Timeout Timer

This block watches the receive side of a UART and reports when received data has been sitting unread for too long. While the receive buffer holds at least one character, it counts ticks of the 16x oversampling baud clock. If neither a new character arrives nor the host reads the holding register during four full character times, it raises a level timeout flag. The host's interrupt logic can use that flag to collect a partly filled buffer.

The length of a character time comes from the programmed line settings: one start bit, five to eight data bits, an optional parity bit, and one, one-and-a-half or two stop bits. All counting is done in 16x ticks, so the one-and-a-half stop case is exact. The threshold is 64 ticks for each whole bit of the frame. When the half stop bit is selected, 32 more ticks are added.

The flag stays set until the count is restarted. A holding-register read restarts the count, and so does a new character being written into the buffer. The buffer going empty also clears the flag and holds the counter at zero.

Top module: `rx_idle_timeout`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `timeout` is 0.
- R2: `dataLen` selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. With no parity and one stop bit, `timeout` rises on the edge of the tick that completes 64×(1+data+1) counted ticks since the last restart, and not before.
- R3: `parityEn`=1 adds one bit, which is 64 ticks, to the threshold.
- R4: `stopLen` selects the stop length: 00 gives 1 bit, 01 gives 1.5 bits (64×(frame with one stop bit)+32 ticks), and 10 or 11 gives 2 bits.
- R5: A cycle with `rhrRead`=1 sets the count to zero and clears `timeout` on the next edge. Counting resumes from zero.
- R6: A cycle with `charWr`=1 has the same restart effect as R5.
- R7: While `notEmpty`=0, no ticks are counted and `timeout` is 0 from the next edge on.
- R8: Once set, `timeout` stays at 1 under any further ticks until a restart of R5, R6 or R7.
- R9: Only cycles with `tick16`=1 advance the count. Idle cycles between ticks never change `timeout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle strobe at 16 times the baud rate |
| dataLen | input | 2 | Data length select (5 to 8 bits) |
| parityEn | input | 1 | Parity bit present in frame |
| stopLen | input | 2 | Stop length select (1, 1.5, 2 bits) |
| charWr | input | 1 | Strobe: a received character entered the buffer |
| rhrRead | input | 1 | Strobe: host read the receive holding register |
| notEmpty | input | 1 | Receive buffer holds at least one character |
| timeout | output | 1 | Level timeout flag, suited to an interrupt |

## Verification
The bound on the internal count assumes the line settings stay fixed while a count is in progress. The bench therefore changes `dataLen`, `parityEn` and `stopLen` only while `notEmpty` is low, which holds the counter at zero. Each 16x tick is driven as a single-cycle pulse followed by at least one idle cycle. This matches a real oversampling strobe and keeps apart the checks that depend on ticks from those that depend only on time.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  localparam int TICKS_PER_BIT = 16;
  localparam int CHAR_SPAN     = 4;
  localparam int MAX_FRAME     = 12;

  typedef struct packed {
    logic clear;
    logic advance;
  } rxto_strobe_t;
endpackage

// File: rtl/rxto_datapath.sv
module rxto_datapath
  import rxto_pkg::*;
#(
  parameter int TPB   = TICKS_PER_BIT,
  parameter int CHARS = CHAR_SPAN,
  parameter int MAXB  = MAX_FRAME
) (
  input  logic         clk,
  input  logic         rstN,
  input  rxto_strobe_t strobe,
  input  logic [1:0]   dataLen,
  input  logic         parityEn,
  input  logic [1:0]   stopLen,
  output logic         hit
);
  localparam int PER_BIT = CHARS * TPB;
  localparam int HALF    = PER_BIT / 2;
  localparam int CNT_W   = $clog2(PER_BIT * MAXB + HALF + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W-1:0] frameBits;
  logic [CNT_W-1:0] limit;

  always_comb begin
    frameBits = CNT_W'(6) + CNT_W'(dataLen) + CNT_W'(parityEn)
              + (stopLen[1] ? CNT_W'(2) : CNT_W'(1));
    limit     = frameBits * CNT_W'(PER_BIT)
              + ((stopLen == 2'b01) ? CNT_W'(HALF) : CNT_W'(0));
    nextCnt   = cnt + CNT_W'(1);
    hit       = (nextCnt >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                cnt <= '0;
    else if (strobe.clear)    cnt <= '0;
    else if (strobe.advance)  cnt <= nextCnt;
  end

  // R6: any restart strobe leaves the count at zero
  p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (cnt == '0));

  // R2: while counting with stable settings the count stays under the limit
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && $stable(limit)) |-> (cnt < limit));

  // R9: the count moves only on an advance strobe
  p_count_still_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.clear) |=> $stable(cnt));
endmodule

// File: rtl/rxto_ctrl.sv
module rxto_ctrl
  import rxto_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick16,
  input  logic         charWr,
  input  logic         rhrRead,
  input  logic         notEmpty,
  input  logic         hit,
  output rxto_strobe_t strobe,
  output logic         timeout
);
  always_comb begin
    strobe.clear   = rhrRead | charWr | ~notEmpty;
    strobe.advance = tick16 & ~strobe.clear & ~timeout;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      timeout <= 1'b0;
    else if (strobe.clear)          timeout <= 1'b0;
    else if (strobe.advance && hit) timeout <= 1'b1;
  end

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    rhrRead |=> !timeout);

  p_write_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    charWr |=> !timeout);

  p_empty_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    !notEmpty |=> !timeout);

  p_flag_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    (timeout && notEmpty && !rhrRead && !charWr) |=> timeout);

  p_rise_on_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeout) |-> $past(tick16));
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
  import rxto_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic [1:0] dataLen,
  input  logic       parityEn,
  input  logic [1:0] stopLen,
  input  logic       charWr,
  input  logic       rhrRead,
  input  logic       notEmpty,
  output logic       timeout
);
  rxto_strobe_t strobe;
  logic         hit;

  rxto_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick16   (tick16),
    .charWr   (charWr),
    .rhrRead  (rhrRead),
    .notEmpty (notEmpty),
    .hit      (hit),
    .strobe   (strobe),
    .timeout  (timeout)
  );

  rxto_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataLen  (dataLen),
    .parityEn (parityEn),
    .stopLen  (stopLen),
    .hit      (hit)
  );
endmodule

// File: tb/test_rx_idle_timeout.sv
module test_rx_idle_timeout;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic [1:0] dataLen = 2'b00;
  logic       parityEn = 1'b0;
  logic [1:0] stopLen = 2'b00;
  logic       charWr = 1'b0;
  logic       rhrRead = 1'b0;
  logic       notEmpty = 1'b0;
  logic       timeout;

  int  checks = 0;
  int  fails = 0;
  int  cycles = 0;
  bit  done = 1'b0;
  string curReq = "R1";

  int  refCnt = 0;
  bit  refTo = 1'b0;

  always #4 clk = ~clk;

  rx_idle_timeout i_rx_idle_timeout (
    .clk(clk), .rstN(rstN), .tick16(tick16), .dataLen(dataLen),
    .parityEn(parityEn), .stopLen(stopLen), .charWr(charWr),
    .rhrRead(rhrRead), .notEmpty(notEmpty), .timeout(timeout)
  );

  function automatic int limitFor(int dl, int par, int st);
    int bits = 1 + 5 + dl + par + ((st >= 2) ? 2 : 1);
    return 64 * bits + ((st == 1) ? 32 : 0);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: timeout actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference, updated on each edge
  always @(posedge clk) begin
    if (!rstN) begin
      refCnt = 0; refTo = 1'b0;
    end else if (rhrRead || charWr || !notEmpty) begin
      refCnt = 0; refTo = 1'b0;
    end else if (tick16 && !refTo) begin
      refCnt++;
      if (refCnt >= limitFor(dataLen, parityEn, stopLen)) refTo = 1'b1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rstN && !done) check(timeout == refTo, curReq, timeout, refTo);
  end

  initial begin
    wait (cycles > 190000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick16 = 1'b1; @(negedge clk);
      tick16 = 1'b0; @(negedge clk);
    end
  endtask

  task automatic pulseWr();
    charWr = 1'b1; @(negedge clk); charWr = 1'b0; @(negedge clk);
  endtask

  task automatic pulseRd();
    rhrRead = 1'b1; @(negedge clk); rhrRead = 1'b0; @(negedge clk);
  endtask

  task automatic setFormat(int dl, int par, int st);
    notEmpty = 1'b0; @(negedge clk);
    dataLen = 2'(dl); parityEn = 1'(par); stopLen = 2'(st);
    @(negedge clk);
    notEmpty = 1'b1; pulseWr();
  endtask

  initial begin
    int lim;
    @(negedge clk); @(negedge clk);
    check(timeout == 1'b0, "R1", timeout, 0);
    rstN = 1'b1; @(negedge clk);
    check(timeout == 1'b0, "R1", timeout, 0);

    // R2 R3 R4: threshold across all frame formats
    for (int dl = 0; dl < 4; dl++)
      for (int par = 0; par < 2; par++)
        for (int st = 0; st < 4; st++) begin
          curReq = (st != 0) ? "R4" : (par != 0) ? "R3" : "R2";
          setFormat(dl, par, st);
          lim = limitFor(dl, par, st);
          ticks(lim - 1);
          check(timeout == 1'b0, curReq, timeout, 0);
          ticks(1);
          check(timeout == 1'b1, curReq, timeout, 1);
        end

    setFormat(3, 1, 1);
    lim = limitFor(3, 1, 1);

    // R8: flag held under further ticks
    curReq = "R8";
    ticks(lim);
    check(timeout == 1'b1, "R8", timeout, 1);
    ticks(200);
    check(timeout == 1'b1, "R8", timeout, 1);

    // R5: read clears and restarts
    curReq = "R5";
    pulseRd();
    check(timeout == 1'b0, "R5", timeout, 0);
    ticks(lim - 10);
    pulseRd();
    ticks(lim - 1);
    check(timeout == 1'b0, "R5", timeout, 0);
    ticks(1);
    check(timeout == 1'b1, "R5", timeout, 1);

    // R6: new character restarts
    curReq = "R6";
    pulseWr();
    check(timeout == 1'b0, "R6", timeout, 0);
    ticks(lim - 3);
    pulseWr();
    ticks(lim - 1);
    check(timeout == 1'b0, "R6", timeout, 0);
    ticks(1);
    check(timeout == 1'b1, "R6", timeout, 1);

    // R7: empty buffer clears and freezes
    curReq = "R7";
    notEmpty = 1'b0; @(negedge clk);
    check(timeout == 1'b0, "R7", timeout, 0);
    ticks(lim + 20);
    check(timeout == 1'b0, "R7", timeout, 0);
    notEmpty = 1'b1;
    ticks(lim - 1);
    check(timeout == 1'b0, "R7", timeout, 0);
    ticks(1);
    check(timeout == 1'b1, "R7", timeout, 1);

    // R9: idle cycles do not advance
    curReq = "R9";
    pulseRd();
    ticks(lim - 1);
    for (int i = 0; i < 100; i++) @(negedge clk);
    check(timeout == 1'b0, "R9", timeout, 0);
    ticks(1);
    check(timeout == 1'b1, "R9", timeout, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule